// File: doc/BRIEF.md
# Multicycle RISC Datapath with Shared Memory and ALU

This block is the datapath half of a 32-bit multicycle processor. It runs a small load/store subset: add, sub, and, or, slt, addi, lw, sw, beq and j. Each instruction takes several clock cycles. A single arithmetic unit does all of the arithmetic, including the PC increment and the branch-target sum. A single word memory holds both the program and the data.

Between steps, values are held in non-architectural registers: an instruction register, a memory data register, the two operand registers A and B, and an ALU-output register. An external sequencer drives the per-cycle select and enable inputs. In return it gets the opcode and function fields of the held instruction and a zero flag from the arithmetic unit.

The memory image is loaded from a parameter on reset. This lets a system or a bench place a program and its data before the first fetch.

Top module: `mc_datapath`

## Requirements
- R1: While reset is high, the PC, the instruction register and all 32 registers clear to zero, and the memory loads its image from the `INIT_IMAGE` parameter (word i at bits [32i+31:32i]). After reset, `opcode` and `funct` read 0.
- R2: When `ir_we` is high, the instruction register loads the memory word at address bits [7:2], with `iord`=0 selecting the PC and `iord`=1 selecting the ALU-output register. When `ir_we` is low, the instruction register holds. `opcode` is IR[31:26] and `funct` is IR[5:0].
- R3: The PC loads the selected next value when `pc_we` is high. With `src_a_sel`=0 (PC), `src_b_sel`=1 (constant 4), `alu_op`=ADD and `pc_sel`=0 (live ALU result), the PC advances by 4.
- R4: The `alu_op` encodings are AND=000, OR=001, ADD=010, SUB=110 and SLT=111, where SLT is a signed compare giving 1 or 0. `zero` is high exactly when the live ALU result is all zeros.
- R5: The operand selects are `src_a_sel` 0=PC and 1=A, and `src_b_sel` 0=B, 1=4, 2=sign-extended IR[15:0], 3=that value shifted left by 2. A and B load the register values addressed by IR[25:21] and IR[20:16] on every clock.
- R6: On a register write, the destination is IR[15:11] when `reg_dst`=1 and IR[20:16] when `reg_dst`=0. The written value is the ALU-output register when `mem_to_reg`=0 and the memory data register when `mem_to_reg`=1.
- R7: Register 0 always reads as zero, and writes to it have no effect.
- R8: When `mem_we` is high, B is written to the word at the selected address. The memory data register captures the selected memory word on every clock. A load or store address is rs plus the sign-extended immediate.
- R9: The PC also loads when `branch` and `zero` are both high. With `pc_sel`=1 it takes the ALU-output register, which holds the branch target computed in the decode cycle. If `zero` is low, the PC holds.
- R10: With `pc_sel`=2 the next PC is {PC[31:28], IR[25:0], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Unconditional PC load |
| branch | input | 1 | PC load qualified by zero |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU-output register |
| mem_we | input | 1 | Memory write enable |
| ir_we | input | 1 | Instruction register load |
| reg_dst | input | 1 | Destination select: 1 rd, 0 rt |
| mem_to_reg | input | 1 | Write-back select: 1 memory data register, 0 ALU output |
| reg_we | input | 1 | Register file write enable |
| src_a_sel | input | 1 | ALU A select: 0 PC, 1 A |
| src_b_sel | input | 2 | ALU B select: B, 4, imm, imm<<2 |
| alu_op | input | 3 | ALU operation code |
| pc_sel | input | 2 | Next-PC select: ALU, ALU-output reg, jump |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | Live ALU result is zero |

## Verification
The bound checker watches several rules on every cycle:
- the instruction register holds whenever its load enable is low;
- the PC holds unless an unconditional load, or a branch with zero high, is requested;
- a fetch-style control set advances the PC by exactly 4;
- a taken branch lands on the value held in the ALU-output register;
- register 0 reads as zero.

Arithmetic results, destination selection, load and store addressing, sign extension, and the branch and jump targets can only be shown by the bench. It plays the sequencer through a short program that has probe instructions between the working ones. Each probe compares a register with an immediate through the zero flag. Every fetch also checks the expected opcode, which shows that branches and jumps reached their targets.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RAW     = $clog2(NREGS);

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG  = 2'd0,
        SRCB_FOUR = 2'd1,
        SRCB_IMM  = 2'd2,
        SRCB_IMM4 = 2'd3
    } srcb_e;

    typedef enum logic [1:0] {
        NPC_ALU  = 2'd0,
        NPC_HOLD = 2'd1,
        NPC_JUMP = 2'd2
    } npc_e;

    typedef struct packed {
        logic [5:0]     op;
        logic [RAW-1:0] rs;
        logic [RAW-1:0] rt;
        logic [RAW-1:0] rd;
        logic [4:0]     sh;
        logic [5:0]     fn;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            z
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign z = (y == '0);
endmodule

// File: rtl/mc_mem.sv
module mc_mem
    import mc_pkg::*;
#(
    parameter int WORDS = 64,
    parameter logic [WORDS*XLEN-1:0] INIT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] addr,
    input  logic            we,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] rd
);
    localparam int AW = $clog2(WORDS);

    logic [XLEN-1:0] words [WORDS];
    logic [AW-1:0]   idx;

    assign idx = addr[AW+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) words[i] <= INIT[i*XLEN +: XLEN];
        end else if (we) begin
            words[idx] <= wd;
        end
    end

    assign rd = words[idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter logic [MEM_WORDS*32-1:0] INIT_IMAGE = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pc_we,
    input  logic       branch,
    input  logic       iord,
    input  logic       mem_we,
    input  logic       ir_we,
    input  logic       reg_dst,
    input  logic       mem_to_reg,
    input  logic       reg_we,
    input  logic       src_a_sel,
    input  logic [1:0] src_b_sel,
    input  logic [2:0] alu_op,
    input  logic [1:0] pc_sel,
    output logic [5:0] opcode,
    output logic [5:0] funct,
    output logic       zero
);
    logic [XLEN-1:0] pc, pc_next, mem_addr, mem_rd;
    logic [XLEN-1:0] a_q, b_q, mdr_q, aluout_q;
    logic [XLEN-1:0] rd_a, rd_b, src_a, src_b, alu_y, imm_x, wb_data;
    logic [RAW-1:0]  wb_addr;
    instr_t          ir;
    logic            pc_load;

    assign imm_x = sext16({ir.rd, ir.sh, ir.fn});

    assign mem_addr = iord ? aluout_q : pc;

    mc_mem #(.WORDS(MEM_WORDS), .INIT(INIT_IMAGE)) u_mem (
        .clk(clk), .rst(rst), .addr(mem_addr), .we(mem_we), .wd(b_q), .rd(mem_rd)
    );

    assign wb_addr = reg_dst ? ir.rd : ir.rt;
    assign wb_data = mem_to_reg ? mdr_q : aluout_q;

    mc_regfile u_rf (
        .clk(clk), .rst(rst), .ra1(ir.rs), .ra2(ir.rt), .rd1(rd_a), .rd2(rd_b),
        .we(reg_we), .wa(wb_addr), .wd(wb_data)
    );

    always_comb begin
        src_a = src_a_sel ? a_q : pc;
        unique case (srcb_e'(src_b_sel))
            SRCB_REG:  src_b = b_q;
            SRCB_FOUR: src_b = 32'd4;
            SRCB_IMM:  src_b = imm_x;
            SRCB_IMM4: src_b = {imm_x[XLEN-3:0], 2'b00};
            default:   src_b = b_q;
        endcase
    end

    mc_alu u_alu (.a(src_a), .b(src_b), .op(alu_op_e'(alu_op)), .y(alu_y), .z(zero));

    always_comb begin
        unique case (npc_e'(pc_sel))
            NPC_ALU:  pc_next = alu_y;
            NPC_HOLD: pc_next = aluout_q;
            NPC_JUMP: pc_next = {pc[31:28], ir.rs, ir.rt, imm_x[15:0], 2'b00};
            default:  pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_we | (branch & zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            ir       <= '0;
            a_q      <= '0;
            b_q      <= '0;
            mdr_q    <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_load) pc <= pc_next;
            if (ir_we)   ir <= instr_t'(mem_rd);
            a_q      <= rd_a;
            b_q      <= rd_b;
            mdr_q    <= mem_rd;
            aluout_q <= alu_y;
        end
    end

    assign opcode = ir.op;
    assign funct  = ir.fn;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        ir_we,
    input logic        pc_we,
    input logic        branch,
    input logic        zero,
    input logic        src_a_sel,
    input logic [1:0]  src_b_sel,
    input logic [2:0]  alu_op,
    input logic [1:0]  pc_sel,
    input logic [31:0] pc,
    input logic [31:0] ir_bits,
    input logic [31:0] aluout_q,
    input logic [31:0] rd_a
);
    a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir_bits));

    a_r9_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !(branch && zero)) |=> $stable(pc));

    a_r3_pc_plus4: assert property (@(posedge clk) disable iff (rst)
        (pc_we && !src_a_sel && src_b_sel == 2'd1 && alu_op == 3'b010 && pc_sel == 2'd0)
        |=> pc == $past(pc) + 32'd4);

    a_r9_branch_target: assert property (@(posedge clk) disable iff (rst)
        (branch && zero && pc_sel == 2'd1) |=> pc == $past(aluout_q));

    a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (ir_bits[25:21] == 5'd0) |-> rd_a == 32'd0);
endmodule

bind mc_datapath mc_datapath_chk u_chk (
    .clk(clk), .rst(rst), .ir_we(ir_we), .pc_we(pc_we), .branch(branch), .zero(zero),
    .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .alu_op(alu_op), .pc_sel(pc_sel),
    .pc(pc), .ir_bits(ir), .aluout_q(aluout_q), .rd_a(rd_a)
);

// File: tb/sim_mc_datapath.sv
module sim_mc_datapath;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 64;

    localparam logic [5:0] OP_R = 6'h00, OP_ADDI = 6'h08, OP_LW = 6'h23, OP_SW = 6'h2B;
    localparam logic [5:0] OP_BEQ = 6'h04, OP_J = 6'h02, OP_PRB = 6'h0A, OP_FILL = 6'h3F;
    localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24, FN_OR = 6'h25, FN_SLT = 6'h2A;
    localparam logic [2:0] A_AND = 3'b000, A_OR = 3'b001, A_ADD = 3'b010, A_SUB = 3'b110, A_SLT = 3'b111;

    function automatic logic [31:0] ei(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] er(int rs, int rt, int rd, logic [5:0] fn);
        return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [WORDS*32-1:0] build();
        logic [WORDS*32-1:0] m;
        for (int i = 0; i < WORDS; i++) m[i*32 +: 32] = {OP_FILL, 26'd0};
        m[0*32 +: 32]  = ei(OP_ADDI, 0, 1, 16'd5);
        m[1*32 +: 32]  = ei(OP_PRB, 1, 0, 16'd5);
        m[2*32 +: 32]  = ei(OP_ADDI, 0, 2, 16'hFFFD);
        m[3*32 +: 32]  = ei(OP_PRB, 2, 0, 16'hFFFD);
        m[4*32 +: 32]  = er(1, 2, 3, FN_ADD);
        m[5*32 +: 32]  = ei(OP_PRB, 3, 0, 16'd2);
        m[6*32 +: 32]  = er(1, 2, 4, FN_SUB);
        m[7*32 +: 32]  = ei(OP_PRB, 4, 0, 16'd8);
        m[8*32 +: 32]  = er(1, 2, 5, FN_AND);
        m[9*32 +: 32]  = ei(OP_PRB, 5, 0, 16'd5);
        m[10*32 +: 32] = er(1, 2, 6, FN_OR);
        m[11*32 +: 32] = ei(OP_PRB, 6, 0, 16'hFFFD);
        m[12*32 +: 32] = er(2, 1, 7, FN_SLT);
        m[13*32 +: 32] = ei(OP_PRB, 7, 0, 16'd1);
        m[14*32 +: 32] = ei(OP_SW, 0, 4, 16'd200);
        m[15*32 +: 32] = ei(OP_LW, 1, 8, 16'd195);
        m[16*32 +: 32] = ei(OP_PRB, 8, 0, 16'd8);
        m[17*32 +: 32] = ei(OP_ADDI, 0, 0, 16'd7);
        m[18*32 +: 32] = ei(OP_PRB, 0, 0, 16'd0);
        m[19*32 +: 32] = ei(OP_BEQ, 1, 1, 16'd2);
        m[22*32 +: 32] = ei(OP_BEQ, 1, 2, 16'd5);
        m[23*32 +: 32] = {OP_J, 26'd30};
        m[30*32 +: 32] = er(1, 2, 9, FN_SLT);
        m[31*32 +: 32] = ei(OP_PRB, 9, 0, 16'd0);
        return m;
    endfunction

    logic clk = 0, rst = 1;
    logic pc_we, branch, iord, mem_we, ir_we, reg_dst, mem_to_reg, reg_we, src_a_sel;
    logic [1:0] src_b_sel, pc_sel;
    logic [2:0] alu_op;
    logic [5:0] opcode, funct;
    logic zero;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    mc_datapath #(.MEM_WORDS(WORDS), .INIT_IMAGE(build())) u0 (
        .clk(clk), .rst(rst), .pc_we(pc_we), .branch(branch), .iord(iord), .mem_we(mem_we),
        .ir_we(ir_we), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_we(reg_we),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .alu_op(alu_op), .pc_sel(pc_sel),
        .opcode(opcode), .funct(funct), .zero(zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pc_we = 0; branch = 0; iord = 0; mem_we = 0; ir_we = 0; reg_dst = 0;
        mem_to_reg = 0; reg_we = 0; src_a_sel = 0; src_b_sel = 0; alu_op = A_ADD; pc_sel = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic fetch(logic [5:0] eop, logic [5:0] efn, string tag);
        idle();
        ir_we = 1; pc_we = 1; src_b_sel = 1; alu_op = A_ADD;
        tick();
        check({tag, " opcode"}, 32'(opcode), 32'(eop));
        if (eop == OP_R) check({tag, " funct"}, 32'(funct), 32'(efn));
    endtask

    task automatic decode();
        idle();
        src_b_sel = 3; alu_op = A_ADD;
        tick();
    endtask

    task automatic t_rtype(logic [5:0] fn, logic [2:0] op, string tag);
        fetch(OP_R, fn, tag);
        decode();
        idle(); src_a_sel = 1; src_b_sel = 0; alu_op = op; tick();
        idle(); reg_dst = 1; reg_we = 1; tick();
    endtask

    task automatic t_addi(string tag);
        fetch(OP_ADDI, 6'd0, tag);
        decode();
        idle(); src_a_sel = 1; src_b_sel = 2; alu_op = A_ADD; tick();
        idle(); reg_we = 1; tick();
    endtask

    task automatic t_probe(logic [31:0] val, string tag);
        fetch(OP_PRB, 6'd0, tag);
        decode();
        idle(); src_a_sel = 1; src_b_sel = 2; alu_op = A_SUB; #1;
        check({tag, " zero"}, 32'(zero), 32'd1);
        src_b_sel = 0; alu_op = A_ADD; #1;
        check({tag, " nonzero"}, 32'(zero), (val == 0) ? 32'd1 : 32'd0);
        tick();
    endtask

    task automatic t_sw(string tag);
        fetch(OP_SW, 6'd0, tag);
        decode();
        idle(); src_a_sel = 1; src_b_sel = 2; alu_op = A_ADD; tick();
        idle(); iord = 1; mem_we = 1; tick();
    endtask

    task automatic t_lw(string tag);
        fetch(OP_LW, 6'd0, tag);
        decode();
        idle(); src_a_sel = 1; src_b_sel = 2; alu_op = A_ADD; tick();
        idle(); iord = 1; tick();
        idle(); mem_to_reg = 1; reg_we = 1; tick();
    endtask

    task automatic t_beq(logic exp_z, string tag);
        fetch(OP_BEQ, 6'd0, tag);
        decode();
        idle(); src_a_sel = 1; src_b_sel = 0; alu_op = A_SUB; branch = 1; pc_sel = 1; #1;
        check({tag, " zero"}, 32'(zero), 32'(exp_z));
        tick();
    endtask

    task automatic t_jump(string tag);
        fetch(OP_J, 6'd0, tag);
        decode();
        idle(); pc_we = 1; pc_sel = 2; tick();
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset opcode", 32'(opcode), 32'd0);
        check("R1 reset funct", 32'(funct), 32'd0);
        rst = 0;
        t_addi("R2 R3 addi r1");
        t_probe(32'd5, "R5 R6 r1=5");
        t_addi("R3 addi r2");
        t_probe(32'hFFFFFFFD, "R5 r2=-3 sign ext");
        t_rtype(FN_ADD, A_ADD, "R4 add");
        t_probe(32'd2, "R4 R6 r3=2");
        t_rtype(FN_SUB, A_SUB, "R4 sub");
        t_probe(32'd8, "R4 r4=8");
        t_rtype(FN_AND, A_AND, "R4 and");
        t_probe(32'd5, "R4 r5=5");
        t_rtype(FN_OR, A_OR, "R4 or");
        t_probe(32'hFFFFFFFD, "R4 r6=-3");
        t_rtype(FN_SLT, A_SLT, "R4 slt");
        t_probe(32'd1, "R4 r7=1");
        t_sw("R8 sw");
        t_lw("R8 lw");
        t_probe(32'd8, "R8 r8=8");
        t_addi("R7 addi r0");
        t_probe(32'd0, "R7 r0 stays 0");
        t_beq(1'b1, "R9 beq taken");
        t_beq(1'b0, "R9 beq target/not taken");
        t_jump("R9 fallthrough jump");
        t_rtype(FN_SLT, A_SLT, "R10 jump target slt");
        t_probe(32'd0, "R4 r9=0");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<5000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule